// File: doc/BRIEF.md
# ASK Separator Pattern Generator

This block produces the fixed amplitude-shift-keyed separator that a low-frequency tag emulator places at the end of a Manchester-coded frame, once every data bit has been sent. An upstream sequencer gives it the bit-clock length in carrier cycles, the selected line encoding and a separator-enable flag, and pulses a start strobe. The block then emits one modulation sample for each carrier tick and follows an asymmetric five-segment on/off shape built from half-clock units.

When the last sample is out, a single-cycle done flag marks it. A running sample count lets the sequencer move its playback pointer by exactly the number of samples emitted. That count is four bit-clock lengths for a separator and zero when no separator applies. Data bits, Manchester coding, output inversion and the field drive are all handled outside the block.

Top module: `ask_sep_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, mod_o, busy_o, done_o and sample_cnt_o are all 0. Reset may be applied in the middle of a pattern.
- R2: A start strobe seen while idle is accepted only when sep_en_i is 1 and enc_sel_i equals 2'b01, the Manchester code. Any other start seen while idle leaves busy_o at 0, clears sample_cnt_o to 0 and leaves mod_o unchanged. Ticks that follow it produce no samples.
- R3: The bit length L is taken from bit_len_i when a start is accepted. Any value below 2 is used as 2. The half unit H is floor(L/2).
- R4: For sample index n (starting at 0), the emitted level is as follows. It is high for n < H and low for H <= n < 2H. It is high for L <= n < 2L+H and low for 2L+H <= n < 2L+2H. It is high for 3L <= n < 4L.
- R5: Sample positions that no segment covers (2H <= n < L and 2L+2H <= n < 3L, which exist only when L is odd) keep the level driven just before them.
- R6: A pattern emits exactly 4L samples. busy_o is 1 from the cycle after an accepted start until the last sample is emitted.
- R7: done_o is high for exactly one cycle, the cycle in which the last sample appears on mod_o. In that cycle busy_o is already 0.
- R8: sample_cnt_o goes to 0 on an accepted start and rises by one for each emitted sample. It holds its final value after the pattern ends.
- R9: A start strobe received while busy_o is 1 is ignored. The pattern's length and shape are unchanged by it.
- R10: Each tick_i pulse while busy emits exactly one sample, visible one clock later. Without a tick, mod_o and sample_cnt_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to emit the separator |
| sep_en_i | input | 1 | Separator option enabled |
| enc_sel_i | input | 2 | Line encoding selected upstream (2'b01 = Manchester) |
| bit_len_i | input | 8 | Bit-clock length in carrier cycles |
| tick_i | input | 1 | Carrier tick, one sample per pulse |
| mod_o | output | 1 | Modulation level |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle pulse on the last sample |
| sample_cnt_o | output | 10 | Samples emitted by the current or last pattern |

## Verification
The assertions assume that every input is a known value, sampled on the rising clock edge, once reset is released. They also assume that a start strobe is judged against busy_o in the same cycle, so a strobe overlapping a running pattern counts as one sent while busy. The bench changes every input only on the falling edge and holds start_i for exactly one cycle. It spaces ticks both back-to-back and with idle cycles between them, so the checks for steady output between ticks are actually exercised. bit_len_i may change while busy, because the length is captured at the start.

// File: rtl/sepgen_pkg.sv
package sepgen_pkg;
  typedef enum logic [1:0] {
    DRV_HOLD = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2
  } drive_e;

  localparam int NUM_SEG = 5;
  localparam logic [1:0] ENC_MANCHESTER = 2'b01;
  localparam int MIN_LEN = 2;
endpackage

// File: rtl/sepgen_len_unit.sv
// Captures the bit length at an accepted start, clamps it, and derives
// the half unit and the total pattern length.
module sepgen_len_unit #(
  parameter int LEN_W = 8,
  localparam int POS_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  output logic [POS_W-1:0] len_q,
  output logic [POS_W-1:0] half_q,
  output logic [POS_W-1:0] total_q
);
  import sepgen_pkg::*;

  logic [LEN_W-1:0] clamped;

  always_comb begin
    if (len_in < LEN_W'(MIN_LEN)) clamped = LEN_W'(MIN_LEN);
    else                          clamped = len_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= POS_W'(MIN_LEN);
      half_q  <= POS_W'(MIN_LEN / 2);
      total_q <= POS_W'(MIN_LEN * 4);
    end else if (load) begin
      len_q   <= POS_W'(clamped);
      half_q  <= POS_W'(clamped >> 1);
      total_q <= {clamped, 2'b00};
    end
  end
endmodule

// File: rtl/sepgen_seg_decode.sv
// Maps a sample position to a drive action. Each segment spans
// [a*L + b*H, c*L + d*H); positions that no segment covers return HOLD.
module sepgen_seg_decode #(
  parameter int LEN_W = 8,
  localparam int POS_W = LEN_W + 2
) (
  input  logic [POS_W-1:0]   pos,
  input  logic [POS_W-1:0]   len,
  input  logic [POS_W-1:0]   half,
  output sepgen_pkg::drive_e drive
);
  import sepgen_pkg::*;

  localparam int LO_L [NUM_SEG] = '{0, 0, 1, 2, 3};
  localparam int LO_H [NUM_SEG] = '{0, 1, 0, 1, 0};
  localparam int HI_L [NUM_SEG] = '{0, 0, 2, 2, 4};
  localparam int HI_H [NUM_SEG] = '{1, 2, 1, 2, 0};
  localparam bit LEVEL [NUM_SEG] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic [NUM_SEG-1:0] hit;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [POS_W-1:0] lo, hi;
    assign lo = POS_W'(LO_L[g]) * len + POS_W'(LO_H[g]) * half;
    assign hi = POS_W'(HI_L[g]) * len + POS_W'(HI_H[g]) * half;
    assign hit[g] = (pos >= lo) && (pos < hi);
  end

  always_comb begin
    drive = DRV_HOLD;
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (hit[i]) drive = LEVEL[i] ? DRV_HIGH : DRV_LOW;
    end
  end
endmodule

// File: rtl/sepgen_sequencer.sv
// Walks the sample position one step per tick and registers every output.
module sepgen_sequencer #(
  parameter int LEN_W = 8,
  localparam int POS_W = LEN_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               clr,
  input  logic               tick,
  input  logic [POS_W-1:0]   total,
  input  sepgen_pkg::drive_e drive,
  output logic [POS_W-1:0]   pos,
  output logic               busy,
  output logic               done,
  output logic               mod,
  output logic [POS_W-1:0]   cnt
);
  import sepgen_pkg::*;

  logic last;
  assign last = (pos == total - POS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      mod  <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        pos  <= '0;
        cnt  <= '0;
      end else if (clr) begin
        cnt <= '0;
      end else if (busy && tick) begin
        case (drive)
          DRV_HIGH: mod <= 1'b1;
          DRV_LOW:  mod <= 1'b0;
          default:  mod <= mod;
        endcase
        pos <= pos + POS_W'(1);
        cnt <= cnt + POS_W'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ask_sep_gen.sv
module ask_sep_gen #(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sep_en_i,
  input  logic [1:0]       enc_sel_i,
  input  logic [LEN_W-1:0] bit_len_i,
  input  logic             tick_i,
  output logic             mod_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] sample_cnt_o
);
  import sepgen_pkg::*;

  logic             eligible, go, clr;
  logic [CNT_W-1:0] len_q, half_q, total_q, pos;
  drive_e           drive;

  assign eligible = sep_en_i && (enc_sel_i == ENC_MANCHESTER);
  assign go  = start_i && !busy_o && eligible;
  assign clr = start_i && !busy_o && !eligible;

  sepgen_len_unit #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .load(go), .len_in(bit_len_i),
    .len_q(len_q), .half_q(half_q), .total_q(total_q)
  );

  sepgen_seg_decode #(.LEN_W(LEN_W)) u_dec (
    .pos(pos), .len(len_q), .half(half_q), .drive(drive)
  );

  sepgen_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .clr(clr), .tick(tick_i),
    .total(total_q), .drive(drive), .pos(pos), .busy(busy_o),
    .done(done_o), .mod(mod_o), .cnt(sample_cnt_o)
  );
endmodule

// File: rtl/ask_sep_gen_chk.sv
module ask_sep_gen_chk #(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             sep_en_i,
  input logic [1:0]       enc_sel_i,
  input logic [LEN_W-1:0] bit_len_i,
  input logic             tick_i,
  input logic             mod_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] sample_cnt_o
);
  logic             ok_req;
  logic [CNT_W-1:0] len_seen;

  assign ok_req = sep_en_i && (enc_sel_i == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) len_seen <= CNT_W'(2);
    else if (start_i && !busy_o && ok_req)
      len_seen <= (bit_len_i < LEN_W'(2)) ? CNT_W'(2) : CNT_W'(bit_len_i);
  end

  assert_reject_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !ok_req) |=> (!busy_o && sample_cnt_o == '0));

  assert_total_len_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sample_cnt_o == {len_seen[CNT_W-3:0], 2'b00}));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick_i) |=> (sample_cnt_o == CNT_W'($past(sample_cnt_o) + 1'b1)));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !tick_i) |=> busy_o);

  assert_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i) |=> ($stable(mod_o) && $stable(sample_cnt_o)));
endmodule

bind ask_sep_gen ask_sep_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .sep_en_i(sep_en_i),
  .enc_sel_i(enc_sel_i), .bit_len_i(bit_len_i), .tick_i(tick_i),
  .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o), .sample_cnt_o(sample_cnt_o)
);

// File: tb/ask_sep_gen_test.sv
module ask_sep_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       sep_en_i = 1'b0;
  logic [1:0] enc_sel_i = 2'b00;
  logic [7:0] bit_len_i = 8'd0;
  logic       tick_i = 1'b0;
  logic       mod_o, busy_o, done_o;
  logic [9:0] sample_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ask_sep_gen uut (
    .clk(clk), .rst(rst), .start_i(start_i), .sep_en_i(sep_en_i),
    .enc_sel_i(enc_sel_i), .bit_len_i(bit_len_i), .tick_i(tick_i),
    .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o), .sample_cnt_o(sample_cnt_o)
  );

  // {len[7:0], enc[1:0], sep_en, spaced_ticks}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {8'd8,   2'b01, 1'b1, 1'b0},
    {8'd5,   2'b01, 1'b1, 1'b1},
    {8'd2,   2'b01, 1'b1, 1'b0},
    {8'd0,   2'b01, 1'b1, 1'b0},
    {8'd1,   2'b01, 1'b1, 1'b1},
    {8'd7,   2'b00, 1'b1, 1'b0},
    {8'd9,   2'b01, 1'b0, 1'b0},
    {8'd3,   2'b10, 1'b1, 1'b0},
    {8'd13,  2'b01, 1'b1, 1'b0},
    {8'd255, 2'b01, 1'b1, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Level from R4/R5: 1 high, 0 low, -1 keep previous
  function automatic int ref_level(int L, int n);
    int h = L / 2;
    if (n < h) return 1;
    if (n < 2 * h) return 0;
    if (n < L) return -1;
    if (n < 2 * L + h) return 1;
    if (n < 2 * L + 2 * h) return 0;
    if (n < 3 * L) return -1;
    return 1;
  endfunction

  task automatic pulse_start(int len, int enc, int en);
    @(negedge clk);
    bit_len_i = 8'(len); enc_sel_i = 2'(enc); sep_en_i = en[0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic tick_once();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic run_vec(int len, int enc, int en, int spaced);
    int L = (len < 2) ? 2 : len;
    int total = 4 * L;
    int prev = int'(mod_o);
    bit ok = (en == 1) && (enc == 1);
    pulse_start(len, enc, en);
    if (!ok) begin
      chk("R2 busy after rejected start", int'(busy_o), 0);
      chk("R2 count after rejected start", int'(sample_cnt_o), 0);
      for (int k = 0; k < 4; k++) tick_once();
      chk("R2 mod unchanged", int'(mod_o), prev);
      chk("R2 still idle", int'(busy_o) + int'(done_o), 0);
      chk("R2 no samples", int'(sample_cnt_o), 0);
      return;
    end
    chk("R6 busy after start", int'(busy_o), 1);
    chk("R8 count cleared", int'(sample_cnt_o), 0);
    bit_len_i = 8'd77;  // R3: length is captured at start
    for (int n = 0; n < total; n++) begin
      int e = ref_level(L, n);
      if (spaced != 0) begin
        @(negedge clk);
        @(negedge clk);
        chk("R10 stable without tick", int'(mod_o), prev);
        chk("R10 count stable without tick", int'(sample_cnt_o), n);
      end
      tick_once();
      if (e >= 0) prev = e;
      chk((e < 0) ? "R5 hold level" : "R4 R3 level", int'(mod_o), prev);
      chk("R7 done position", int'(done_o), (n == total - 1) ? 1 : 0);
      chk("R8 sample count", int'(sample_cnt_o), n + 1);
    end
    chk("R6 idle after 4L samples", int'(busy_o), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(done_o), 0);
    tick_once();
    chk("R8 count holds", int'(sample_cnt_o), total);
  endtask

  initial begin
    #(100000 * 20);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mod in reset", int'(mod_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 count after reset", int'(sample_cnt_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VEC[v][11:4]), int'(VEC[v][3:2]), int'(VEC[v][1]), int'(VEC[v][0]));

    // R9: start while busy is ignored
    pulse_start(6, 1, 1);
    for (int n = 0; n < 5; n++) tick_once();
    pulse_start(20, 1, 1);
    chk("R9 busy kept", int'(busy_o), 1);
    chk("R9 count kept", int'(sample_cnt_o), 5);
    for (int n = 5; n < 24; n++) begin
      tick_once();
      chk("R9 length unchanged", int'(done_o), (n == 23) ? 1 : 0);
    end
    chk("R9 final count", int'(sample_cnt_o), 24);

    // R1: reset in the middle of a pattern
    pulse_start(10, 1, 1);
    for (int n = 0; n < 3; n++) tick_once();
    chk("R4 mid-pattern level", int'(mod_o), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mod after mid reset", int'(mod_o), 0);
    chk("R1 busy after mid reset", int'(busy_o), 0);
    chk("R1 count after mid reset", int'(sample_cnt_o), 0);
    tick_once();
    chk("R1 idle ticks do nothing", int'(sample_cnt_o), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule